// File: doc/BRIEF.md
# Single-Bank Synchronous DRAM Model with Row Latch

This block is a synthesizable behavioural model of one bank of a synchronous DRAM. A 3-bit command bus, a shared address bus and a 4-bit data bus are sampled on each rising clock edge. Every access goes through a row latch that holds one whole row of the array. Opening a row copies it into the latch and leaves the array row cleared, which models a destructive sense. Column reads and writes then act on the latch alone. Closing the row writes the latch back into the array. A refresh command cycles one row at a time through the latch, using an internal row counter.

Read data passes through a pipeline whose depth is the CAS latency. Both reads and writes can be bursts of successive columns on consecutive clocks. The burst length comes with each column command. The array has as many rows as a parameter sets, so a simulation can keep the full 12-bit row and 10-bit column address widths while holding only a few rows.

Top module: `sdb_bank`

## Requirements
- R1: Commands are decoded from `cmd` as 000 no-op, 001 open row, 010 column read, 011 column write, 100 close row, 101 refresh. The codes 110 and 111 act as no-ops. The row address is taken from `addr` with the open command, and the column from `addr[9:0]` with a read or write. With ROWS rows (a power of two), the row used is the low log2(ROWS) bits of the row address.
- R2: A column read sampled on edge E puts that column's 4-bit word from the row latch on `dq_out` with `dq_valid` high from edge E+CAS_LAT onward.
- R3: A column write merges the `dq_in` value sampled on the same edge as the command into the addressed column of the row latch. The other columns keep their values.
- R4: `bl_sel` sampled with a read or write sets the burst length: 0 gives 1 word, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives the full page of 1024 columns, and any other code gives 1. A burst covers successive columns on consecutive clocks and wraps from column 1023 to column 0. Write beat k takes `dq_in` on edge E+k, and read beat k appears after edge E+CAS_LAT+k.
- R5: Any command other than a no-op ends a running burst. No further beat of the old burst is read or written from the edge on which that command is sampled.
- R6: Closing a row writes the latch back into that row. Data written to a row can be read again after the row is closed and reopened, and after other rows have been opened and closed.
- R7: A refresh takes no address. It copies the row named by an internal 12-bit refresh counter into the latch, writes it back unchanged, and then increments the counter. No stored data changes.
- R8: `proto_err` goes high one edge after a read, write or close is issued with no open row, or an open or refresh is issued while a row is open. It stays high until reset. The rejected command changes neither the array nor the latch.
- R9: When no read beat is due, `dq_valid` is low and `dq_out` is 0. A synchronous reset clears the array, the latch, the refresh counter, the read pipeline and `proto_err`, and leaves the bank with no open row.
- R10: The CAS latency is a parameter `CAS_LAT` that may be 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command code |
| addr | input | 12 | Row address for an open command, column address in bits 9:0 for a read or write |
| bl_sel | input | 3 | Burst length code, sampled with a read or write |
| dq_in | input | 4 | Write data, one word per write beat |
| dq_out | output | 4 | Read data, zero when no read beat is due |
| dq_valid | output | 1 | High when `dq_out` carries a read beat (stands in for a driven bus) |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
A write beat takes effect on the edge that samples it. The bench can see it only through a later read, so every write is checked by reading the same columns back. A read beat issued on edge E is due after edge E+CAS_LAT, with one further edge for each later beat of the burst. The vector table therefore places each expected word exactly CAS_LAT rows below its command, and all outputs are compared at the falling edge after each rising edge. A protocol error is due one edge after the offending command and is checked at that point. Checks in later cycles confirm that it stays set and that the latch kept its contents.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

    localparam int DQ_W = 4;

    typedef logic [DQ_W-1:0] dq_t;

    typedef enum logic [2:0] {
        OP_IDLE    = 3'b000,
        OP_OPEN    = 3'b001,
        OP_RD      = 3'b010,
        OP_WR      = 3'b011,
        OP_CLOSE   = 3'b100,
        OP_REFRESH = 3'b101
    } bank_op_e;

    typedef struct packed {
        logic vld;
        dq_t  dat;
    } rd_slot_t;

    // Number of beats for a burst code; page is the number of columns per row.
    function automatic int unsigned burst_beats(input logic [2:0] code, input int unsigned page);
        case (code)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 8;
            3'd7:    return page;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/sdb_cmd_ctl.sv
module sdb_cmd_ctl
    import sdb_pkg::*;
#(
    parameter int RIDX_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cmd,
    input  logic [RIDX_W-1:0] row_idx,
    output logic              do_open,
    output logic              do_rd,
    output logic              do_wr,
    output logic              do_close,
    output logic              do_ref,
    output logic              row_open,
    output logic [RIDX_W-1:0] open_idx,
    output logic              proto_err
);

    logic bad_cmd;

    always_comb begin
        do_open  = 1'b0;
        do_rd    = 1'b0;
        do_wr    = 1'b0;
        do_close = 1'b0;
        do_ref   = 1'b0;
        bad_cmd  = 1'b0;
        case (cmd)
            OP_OPEN:    if (row_open) bad_cmd = 1'b1; else do_open = 1'b1;
            OP_REFRESH: if (row_open) bad_cmd = 1'b1; else do_ref  = 1'b1;
            OP_RD:      if (row_open) do_rd    = 1'b1; else bad_cmd = 1'b1;
            OP_WR:      if (row_open) do_wr    = 1'b1; else bad_cmd = 1'b1;
            OP_CLOSE:   if (row_open) do_close = 1'b1; else bad_cmd = 1'b1;
            default:    ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_open  <= 1'b0;
            open_idx  <= '0;
            proto_err <= 1'b0;
        end else begin
            if (do_open) begin
                row_open <= 1'b1;
                open_idx <= row_idx;
            end
            if (do_close) row_open <= 1'b0;
            if (bad_cmd) proto_err <= 1'b1;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err); // R8

endmodule

// File: rtl/sdb_burst_ctl.sv
module sdb_burst_ctl #(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_idle,
    input  logic             start_rd,
    input  logic             start_wr,
    input  logic [COL_W-1:0] col,
    input  logic [COL_W:0]   beats,
    output logic             rd_en,
    output logic [COL_W-1:0] rd_col,
    output logic             wr_en,
    output logic [COL_W-1:0] wr_col
);

    localparam int LEFT_W = COL_W + 1;

    logic              act_rd;
    logic              act_wr;
    logic [COL_W-1:0]  ptr;
    logic [LEFT_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_rd <= 1'b0;
            act_wr <= 1'b0;
            ptr    <= '0;
            left   <= '0;
        end else if (!cmd_idle) begin
            act_rd <= start_rd;
            act_wr <= start_wr && (beats > LEFT_W'(1));
            ptr    <= start_rd ? col : col + 1'b1;
            left   <= start_rd ? beats : beats - 1'b1;
        end else if (act_rd || act_wr) begin
            ptr  <= ptr + 1'b1;
            left <= left - 1'b1;
            if (left == LEFT_W'(1)) begin
                act_rd <= 1'b0;
                act_wr <= 1'b0;
            end
        end
    end

    assign rd_en  = act_rd && cmd_idle;
    assign rd_col = ptr;
    assign wr_en  = start_wr || (act_wr && cmd_idle);
    assign wr_col = start_wr ? col : ptr;

    AST_LEFT_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (act_rd || act_wr) |-> (left != '0)); // R4

endmodule

// File: rtl/sdb_rd_pipe.sv
module sdb_rd_pipe
    import sdb_pkg::*;
#(
    parameter int CAS_LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  dq_t  dat,
    output logic dq_valid,
    output dq_t  dq_out
);

    rd_slot_t stage [CAS_LAT];

    generate
        for (genvar s = 0; s < CAS_LAT; s++) begin : g_stage
            if (s == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) stage[0] <= '0;
                    else     stage[0] <= '{vld: load, dat: load ? dat : '0};
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= '0;
                    else     stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign dq_valid = stage[CAS_LAT-1].vld;
    assign dq_out   = stage[CAS_LAT-1].vld ? stage[CAS_LAT-1].dat : '0;

endmodule

// File: rtl/sdb_bank.sv
module sdb_bank
    import sdb_pkg::*;
#(
    parameter int ROW_W   = 12,
    parameter int COL_W   = 10,
    parameter int ROWS    = 4,
    parameter int CAS_LAT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       cmd,
    input  logic [ROW_W-1:0] addr,
    input  logic [2:0]       bl_sel,
    input  logic [DQ_W-1:0]  dq_in,
    output logic [DQ_W-1:0]  dq_out,
    output logic             dq_valid,
    output logic             proto_err
);

    localparam int RIDX_W = $clog2(ROWS);
    localparam int NCOLS  = 1 << COL_W;
    localparam int LINE_W = DQ_W * NCOLS;

    logic [LINE_W-1:0] cells [ROWS];
    logic [LINE_W-1:0] row_latch;
    logic [ROW_W-1:0]  ref_cnt;

    logic              do_open, do_rd, do_wr, do_close, do_ref, row_open;
    logic [RIDX_W-1:0] open_idx;
    logic [RIDX_W-1:0] ref_idx;
    logic              rd_en, wr_en;
    logic [COL_W-1:0]  rd_col, wr_col;
    logic [COL_W:0]    beats;
    dq_t               rd_word;
    logic              unused_bits;

    assign ref_idx     = ref_cnt[RIDX_W-1:0];
    assign beats       = (COL_W+1)'(burst_beats(bl_sel, NCOLS));
    assign rd_word     = row_latch[rd_col*DQ_W +: DQ_W];
    assign unused_bits = ^{addr[ROW_W-1:RIDX_W], ref_cnt[ROW_W-1:RIDX_W]};

    sdb_cmd_ctl #(.RIDX_W(RIDX_W)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .row_idx   (addr[RIDX_W-1:0]),
        .do_open   (do_open),
        .do_rd     (do_rd),
        .do_wr     (do_wr),
        .do_close  (do_close),
        .do_ref    (do_ref),
        .row_open  (row_open),
        .open_idx  (open_idx),
        .proto_err (proto_err)
    );

    sdb_burst_ctl #(.COL_W(COL_W)) u_burst (
        .clk      (clk),
        .rst      (rst),
        .cmd_idle (cmd == OP_IDLE || cmd == 3'b110 || cmd == 3'b111),
        .start_rd (do_rd),
        .start_wr (do_wr),
        .col      (addr[COL_W-1:0]),
        .beats    (beats),
        .rd_en    (rd_en),
        .rd_col   (rd_col),
        .wr_en    (wr_en),
        .wr_col   (wr_col)
    );

    sdb_rd_pipe #(.CAS_LAT(CAS_LAT)) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .load     (rd_en),
        .dat      (rd_word),
        .dq_valid (dq_valid),
        .dq_out   (dq_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++) cells[r] <= '0;
            row_latch <= '0;
            ref_cnt   <= '0;
        end else if (do_open) begin
            row_latch       <= cells[addr[RIDX_W-1:0]];
            cells[addr[RIDX_W-1:0]] <= '0;
        end else if (do_ref) begin
            row_latch      <= cells[ref_idx];
            cells[ref_idx] <= cells[ref_idx];
            ref_cnt        <= ref_cnt + 1'b1;
        end else begin
            if (wr_en) row_latch[wr_col*DQ_W +: DQ_W] <= dq_in;
            if (do_close) cells[open_idx] <= row_latch;
        end
    end

    AST_WR_NEEDS_ROW: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> row_open); // R3

    AST_RD_NEEDS_ROW: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> row_open); // R5

    AST_REF_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        do_ref |=> (ref_cnt == $past(ref_cnt) + 1'b1)); // R7

endmodule

// File: tb/sdb_bank_bench.sv
module sdb_bank_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  cmd;
    logic [11:0] addr;
    logic [2:0]  bl_sel;
    logic [3:0]  dq_in;
    logic [3:0]  dq_out;
    logic        dq_valid;
    logic        proto_err;

    int n_vec  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    sdb_bank u_sdb_bank (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .addr      (addr),
        .bl_sel    (bl_sel),
        .dq_in     (dq_in),
        .dq_out    (dq_out),
        .dq_valid  (dq_valid),
        .proto_err (proto_err)
    );

    // {req, cmd, addr, bl_sel, dq_in, exp_valid, exp_dq, exp_err}
    localparam int NV = 37;
    localparam logic [31:0] VEC [NV] = '{
        {4'd1, 3'b001, 12'd1, 3'd0, 4'h0, 1'b0, 4'h0, 1'b0},  // 0  R1 open row 1
        {4'd3, 3'b011, 12'd5, 3'd2, 4'hA, 1'b0, 4'h0, 1'b0},  // 1  R3 write col5, 4 beats
        {4'd4, 3'b000, 12'd0, 3'd0, 4'hB, 1'b0, 4'h0, 1'b0},  // 2  R4 beat col6
        {4'd4, 3'b000, 12'd0, 3'd0, 4'hC, 1'b0, 4'h0, 1'b0},  // 3  beat col7
        {4'd4, 3'b000, 12'd0, 3'd0, 4'hD, 1'b0, 4'h0, 1'b0},  // 4  beat col8
        {4'd4, 3'b000, 12'd0, 3'd0, 4'hE, 1'b0, 4'h0, 1'b0},  // 5  past burst end
        {4'd2, 3'b010, 12'd4, 3'd2, 4'h0, 1'b0, 4'h0, 1'b0},  // 6  R2 read col4, 4 beats
        {4'd2, 3'b000, 12'd0, 3'd0, 4'h0, 1'b0, 4'h0, 1'b0},  // 7
        {4'd2, 3'b000, 12'd0, 3'd0, 4'h0, 1'b1, 4'h0, 1'b0},  // 8  col4
        {4'd4, 3'b000, 12'd0, 3'd0, 4'h0, 1'b1, 4'hA, 1'b0},  // 9  col5
        {4'd4, 3'b000, 12'd0, 3'd0, 4'h0, 1'b1, 4'hB, 1'b0},  // 10 col6
        {4'd4, 3'b000, 12'd0, 3'd0, 4'h0, 1'b1, 4'hC, 1'b0},  // 11 col7
        {4'd9, 3'b000, 12'd0, 3'd0, 4'h0, 1'b0, 4'h0, 1'b0},  // 12 R9 bus quiet
        {4'd6, 3'b100, 12'd0, 3'd0, 4'h0, 1'b0, 4'h0, 1'b0},  // 13 R6 close
        {4'd6, 3'b001, 12'd2, 3'd0, 4'h0, 1'b0, 4'h0, 1'b0},  // 14 open row 2
        {4'd6, 3'b010, 12'd5, 3'd0, 4'h0, 1'b0, 4'h0, 1'b0},  // 15 read col5
        {4'd6, 3'b000, 12'd0, 3'd0, 4'h0, 1'b0, 4'h0, 1'b0},  // 16
        {4'd6, 3'b000, 12'd0, 3'd0, 4'h0, 1'b1, 4'h0, 1'b0},  // 17 row 2 untouched
        {4'd6, 3'b100, 12'd0, 3'd0, 4'h0, 1'b0, 4'h0, 1'b0},  // 18 close
        {4'd7, 3'b101, 12'd0, 3'd0, 4'h0, 1'b0, 4'h0, 1'b0},  // 19 R7 refresh row 0
        {4'd7, 3'b101, 12'd0, 3'd0, 4'h0, 1'b0, 4'h0, 1'b0},  // 20 refresh row 1
        {4'd6, 3'b001, 12'd1, 3'd0, 4'h0, 1'b0, 4'h0, 1'b0},  // 21 reopen row 1
        {4'd6, 3'b010, 12'd5, 3'd1, 4'h0, 1'b0, 4'h0, 1'b0},  // 22 read col5, 2 beats
        {4'd6, 3'b000, 12'd0, 3'd0, 4'h0, 1'b0, 4'h0, 1'b0},  // 23
        {4'd7, 3'b000, 12'd0, 3'd0, 4'h0, 1'b1, 4'hA, 1'b0},  // 24 kept through refresh
        {4'd6, 3'b000, 12'd0, 3'd0, 4'h0, 1'b1, 4'hB, 1'b0},  // 25
        {4'd3, 3'b011, 12'd6, 3'd0, 4'h7, 1'b0, 4'h0, 1'b0},  // 26 R3 overwrite col6
        {4'd3, 3'b010, 12'd6, 3'd0, 4'h0, 1'b0, 4'h0, 1'b0},  // 27 read col6
        {4'd3, 3'b000, 12'd0, 3'd0, 4'h0, 1'b0, 4'h0, 1'b0},  // 28
        {4'd3, 3'b000, 12'd0, 3'd0, 4'h0, 1'b1, 4'h7, 1'b0},  // 29 merged value
        {4'd5, 3'b010, 12'd5, 3'd3, 4'h0, 1'b0, 4'h0, 1'b0},  // 30 R5 read col5, 8 beats
        {4'd5, 3'b000, 12'd0, 3'd0, 4'h0, 1'b0, 4'h0, 1'b0},  // 31 beat col5
        {4'd5, 3'b010, 12'd6, 3'd0, 4'h0, 1'b1, 4'hA, 1'b0},  // 32 new read cuts burst
        {4'd5, 3'b000, 12'd0, 3'd0, 4'h0, 1'b0, 4'h0, 1'b0},  // 33 gap, no old beat
        {4'd5, 3'b000, 12'd0, 3'd0, 4'h0, 1'b1, 4'h7, 1'b0},  // 34 new beat col6
        {4'd5, 3'b000, 12'd0, 3'd0, 4'h0, 1'b0, 4'h0, 1'b0},  // 35 old burst stays dead
        {4'd6, 3'b100, 12'd0, 3'd0, 4'h0, 1'b0, 4'h0, 1'b0}   // 36 close
    };

    // Drive inputs (bench stands at a falling edge), take one rising edge, return at the falling edge.
    task automatic cyc(input logic [2:0] c, input logic [11:0] a, input logic [2:0] b, input logic [3:0] d);
        cmd = c; addr = a; bl_sel = b; dq_in = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic ev, input logic [3:0] edq, input logic eerr);
        n_vec++;
        if (dq_valid !== ev || dq_out !== edq || proto_err !== eerr) begin
            n_fail++;
            $display("FAIL %s: valid/dq/err got %b/%h/%b expected %b/%h/%b",
                     req, dq_valid, dq_out, proto_err, ev, edq, eerr);
        end
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; cmd = 3'b000; addr = '0; bl_sel = '0; dq_in = '0;
        @(negedge clk);
        cyc(3'b000, 12'd0, 3'd0, 4'h0);
        cyc(3'b000, 12'd0, 3'd0, 4'h0);
        rst = 1'b0;
        chk("R9 reset state", 1'b0, 4'h0, 1'b0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][27:25], VEC[i][24:13], VEC[i][12:10], VEC[i][9:6]);
            n_vec++;
            if (dq_valid !== VEC[i][5] || dq_out !== VEC[i][4:1] || proto_err !== VEC[i][0]) begin
                n_fail++;
                $display("FAIL R%0d vector %0d: valid/dq/err got %b/%h/%b expected %b/%h/%b",
                         VEC[i][31:28], i, dq_valid, dq_out, proto_err,
                         VEC[i][5], VEC[i][4:1], VEC[i][0]);
            end
        end

        // R4 full-page write burst, then an 8-beat read that wraps past column 1023
        cyc(3'b001, 12'd0, 3'd0, 4'h0);
        cyc(3'b011, 12'd0, 3'd7, 4'h0);
        for (int j = 1; j < 1024; j++) cyc(3'b000, 12'd0, 3'd0, 4'(j));
        cyc(3'b010, 12'd1020, 3'd3, 4'h0);
        cyc(3'b000, 12'd0, 3'd0, 4'h0);
        for (int j = 0; j < 8; j++) begin
            cyc(3'b000, 12'd0, 3'd0, 4'h0);
            chk("R4 page burst wrap", 1'b1, 4'((1020 + j) % 1024), 1'b0);
        end
        cyc(3'b000, 12'd0, 3'd0, 4'h0);
        chk("R4 burst length 8 ends", 1'b0, 4'h0, 1'b0);
        cyc(3'b100, 12'd0, 3'd0, 4'h0);

        // R8 protocol errors
        cyc(3'b011, 12'd0, 3'd0, 4'h5);
        chk("R8 write with no open row", 1'b0, 4'h0, 1'b1);
        cyc(3'b000, 12'd0, 3'd0, 4'h0);
        chk("R8 flag sticky", 1'b0, 4'h0, 1'b1);
        cyc(3'b001, 12'd3, 3'd0, 4'h0);
        cyc(3'b011, 12'd0, 3'd0, 4'h9);
        cyc(3'b001, 12'd0, 3'd0, 4'h0);   // open while open: rejected
        cyc(3'b101, 12'd0, 3'd0, 4'h0);   // refresh while open: rejected
        cyc(3'b010, 12'd0, 3'd0, 4'h0);
        cyc(3'b000, 12'd0, 3'd0, 4'h0);
        cyc(3'b000, 12'd0, 3'd0, 4'h0);
        chk("R8 latch kept after rejected open", 1'b1, 4'h9, 1'b1);
        cyc(3'b100, 12'd0, 3'd0, 4'h0);
        cyc(3'b110, 12'd0, 3'd0, 4'h0);   // R1 reserved code is a no-op
        cyc(3'b001, 12'd3, 3'd0, 4'h0);
        cyc(3'b010, 12'd0, 3'd0, 4'h0);
        cyc(3'b000, 12'd0, 3'd0, 4'h0);
        cyc(3'b000, 12'd0, 3'd0, 4'h0);
        chk("R6 row 3 written back", 1'b1, 4'h9, 1'b1);
        cyc(3'b100, 12'd0, 3'd0, 4'h0);
        cyc(3'b001, 12'd0, 3'd0, 4'h0);
        cyc(3'b010, 12'd0, 3'd0, 4'h0);
        cyc(3'b000, 12'd0, 3'd0, 4'h0);
        cyc(3'b000, 12'd0, 3'd0, 4'h0);
        chk("R8 row 0 col0 intact after rejected write", 1'b1, 4'h0, 1'b1);

        // R9 reset clears flag and array
        rst = 1'b1;
        cyc(3'b000, 12'd0, 3'd0, 4'h0);
        rst = 1'b0;
        chk("R9 reset clears flag", 1'b0, 4'h0, 1'b0);
        cyc(3'b001, 12'd3, 3'd0, 4'h0);
        cyc(3'b010, 12'd0, 3'd0, 4'h0);
        cyc(3'b000, 12'd0, 3'd0, 4'h0);
        chk("R10 no data before CAS latency", 1'b0, 4'h0, 1'b0);
        cyc(3'b000, 12'd0, 3'd0, 4'h0);
        chk("R9 array cleared by reset", 1'b1, 4'h0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule